// File: doc/BRIEF.md
# Per-Port VLAN Tag Classifier

This block decides how many VLAN tags an Ethernet frame carries by looking only at its two candidate EtherType fields. The outer field (tag0) and the inner field (tag1) are compared against three programmable EtherType slots. Every port owns its own pair of enables per slot: an outer enable, which lets a slot count as a tag at the tag0 position, and an inner enable, which lets a slot count as a second tag at the tag1 position. This makes tag recognition programmable per port. For example, one port can treat frames carrying 0x8100 as untagged while frames carrying 0x88A8 are tagged, as a provider bridge needs. The same per-port setting applies whether the port is receiving or transmitting the frame.

A configuration write port loads the slot EtherType values and the per-port enable words. A header port presents one frame per cycle: a port number and the two EtherType fields. The result appears on a registered output one cycle later, together with a valid strobe.

Top module: `vtag_classifier`

## Requirements
- R1: While reset is held and afterwards until the first header is accepted, `cls_valid` is 0 and `cls_kind` is 2'b00. Whenever `cls_valid` is 0, `cls_kind` is 2'b00.
- R2: A frame whose tag0 EtherType equals a slot that has its outer enable set for that port, and whose tag1 does not match any inner-enabled slot, is reported as single tagged, with `cls_kind` = 2'b01.
- R3: A frame that meets the tag0 condition of R2 and whose tag1 EtherType equals a slot that has its inner enable set for that port is reported as double tagged, with `cls_kind` = 2'b10. The code 2'b11 never appears.
- R4: A frame whose tag0 matches no outer-enabled slot is reported as untagged (2'b00), whatever the value of tag1.
- R5: After reset, slot 0 holds 0x8100, slot 1 holds 0x88A8 and slot 2 holds 0x9100. For every port, the outer and inner enables of slots 0 and 1 are set and both enables of slot 2 are clear.
- R6: A write with `cfg_wr_sel`=1 loads the enable word of port `cfg_wr_idx`. The bit positions are: bit 8*s is the outer enable of slot s, and bit 8*s+1 is the inner enable of slot s, for s = 0, 1, 2. Every other bit of the word has no effect.
- R7: A write with `cfg_wr_sel`=0 loads `cfg_wr_data[15:0]` into slot `cfg_wr_idx` when that index is 0, 1 or 2. A write to any other slot index has no effect.
- R8: Each cycle with `hdr_valid`=1 produces exactly one cycle with `cls_valid`=1, on the next clock cycle. No other cycle asserts `cls_valid`.
- R9: When a configuration write and a header arrive in the same cycle, that header is classified with the configuration in force before the write. The write applies from the next header onward.
- R10: A header whose port index is 16 or more is reported as untagged. A port-enable write to such an index has no effect on any port, including the port that shares its low index bits.
- R11: Enable settings are held independently per port. A write to one port leaves the classification of every other port unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 1 | 0: EtherType slot write, 1: port enable word write |
| cfg_wr_idx | input | 8 | Slot number or port number targeted by the write |
| cfg_wr_data | input | 32 | Write data (slot value in bits 15:0, or enable word) |
| hdr_valid | input | 1 | Header present this cycle |
| hdr_port | input | 8 | Port the frame belongs to |
| hdr_et0 | input | 16 | Outer (tag0) EtherType field |
| hdr_et1 | input | 16 | Inner (tag1) EtherType field |
| cls_valid | output | 1 | Classification result valid |
| cls_kind | output | 2 | 00 untagged, 01 single tagged, 10 double tagged |

## Verification
The bench uses the default build of 16 ports with an 8-bit port index. With that build it can send headers and enable writes to indices 16 to 255. Index 20 is one such case: its low four bits alias port 4, so the bench can show that an out-of-range write does not reach port 4. With 16 ports and three slots, a few thousand random cycles visit every port and every combination of slot hits many times. Random configuration writes that land on the same cycle as headers then cover the old-configuration rule of R9.

// File: rtl/vtag_pkg.sv
package vtag_pkg;

    localparam int NUM_SLOTS = 3;
    localparam int ET_W      = 16;
    localparam int CFG_W     = 32;
    localparam int EN_STRIDE = 8;

    typedef enum logic [1:0] {
        VT_UNTAGGED = 2'b00,
        VT_SINGLE   = 2'b01,
        VT_DOUBLE   = 2'b10
    } vtag_kind_e;

    function automatic logic [ET_W-1:0] slot_et_default(input int s);
        case (s)
            0:       return 16'h8100;
            1:       return 16'h88A8;
            default: return 16'h9100;
        endcase
    endfunction

    function automatic logic slot_en_default(input int s);
        return (s < 2);
    endfunction

endpackage

// File: rtl/vtag_cfg_regs.sv
module vtag_cfg_regs
    import vtag_pkg::*;
#(
    parameter int NUM_PORTS = 16,
    parameter int PORT_W    = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic                             wr_sel,
    input  logic [PORT_W-1:0]                wr_idx,
    input  logic [CFG_W-1:0]                 wr_data,
    input  logic [PORT_W-1:0]                look_port,
    output logic                             look_ok,
    output logic [NUM_SLOTS-1:0]             look_outer,
    output logic [NUM_SLOTS-1:0]             look_inner,
    output logic [NUM_SLOTS-1:0][ET_W-1:0]   slot_et
);

    localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    typedef struct packed {
        logic [NUM_SLOTS-1:0][ET_W-1:0]      et;
        logic [NUM_PORTS-1:0][NUM_SLOTS-1:0] outer;
        logic [NUM_PORTS-1:0][NUM_SLOTS-1:0] inner;
    } cfg_t;

    function automatic cfg_t reset_cfg();
        cfg_t c;
        c = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            c.et[s] = slot_et_default(s);
            for (int p = 0; p < NUM_PORTS; p++) begin
                c.outer[p][s] = slot_en_default(s);
                c.inner[p][s] = slot_en_default(s);
            end
        end
        return c;
    endfunction

    localparam cfg_t CFG_RST = reset_cfg();

    cfg_t cfg_d, cfg_q;

    // next-state: slot writes and port enable writes
    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (!wr_sel) begin
                for (int s = 0; s < NUM_SLOTS; s++) begin
                    if (wr_idx == PORT_W'(s)) begin
                        cfg_d.et[s] = wr_data[ET_W-1:0];
                    end
                end
            end else begin
                for (int p = 0; p < NUM_PORTS; p++) begin
                    if (wr_idx == PORT_W'(p)) begin
                        for (int s = 0; s < NUM_SLOTS; s++) begin
                            cfg_d.outer[p][s] = wr_data[s*EN_STRIDE];
                            cfg_d.inner[p][s] = wr_data[s*EN_STRIDE+1];
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // lookup of the enables for the port being classified
    logic [IDX_W-1:0] look_idx;

    always_comb begin
        look_ok    = (int'(look_port) < NUM_PORTS);
        look_idx   = look_port[IDX_W-1:0];
        look_outer = look_ok ? cfg_q.outer[look_idx] : '0;
        look_inner = look_ok ? cfg_q.inner[look_idx] : '0;
    end

    assign slot_et = cfg_q.et;

endmodule

// File: rtl/vtag_slot_match.sv
module vtag_slot_match
    import vtag_pkg::*;
(
    input  logic [ET_W-1:0]                 et,
    input  logic [NUM_SLOTS-1:0][ET_W-1:0]  slot_et,
    input  logic [NUM_SLOTS-1:0]            slot_en,
    output logic                            hit
);

    logic [NUM_SLOTS-1:0] hit_vec;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign hit_vec[g] = slot_en[g] && (et == slot_et[g]);
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/vtag_classifier.sv
module vtag_classifier
    import vtag_pkg::*;
#(
    parameter int NUM_PORTS = 16,
    parameter int PORT_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic              cfg_wr_sel,
    input  logic [PORT_W-1:0] cfg_wr_idx,
    input  logic [CFG_W-1:0]  cfg_wr_data,
    input  logic              hdr_valid,
    input  logic [PORT_W-1:0] hdr_port,
    input  logic [ET_W-1:0]   hdr_et0,
    input  logic [ET_W-1:0]   hdr_et1,
    output logic              cls_valid,
    output logic [1:0]        cls_kind
);

    logic                           port_ok;
    logic [NUM_SLOTS-1:0]           outer_en;
    logic [NUM_SLOTS-1:0]           inner_en;
    logic [NUM_SLOTS-1:0][ET_W-1:0] slot_et;
    logic                           outer_hit;
    logic                           inner_hit;

    vtag_cfg_regs #(
        .NUM_PORTS (NUM_PORTS),
        .PORT_W    (PORT_W)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr_en),
        .wr_sel     (cfg_wr_sel),
        .wr_idx     (cfg_wr_idx),
        .wr_data    (cfg_wr_data),
        .look_port  (hdr_port),
        .look_ok    (port_ok),
        .look_outer (outer_en),
        .look_inner (inner_en),
        .slot_et    (slot_et)
    );

    vtag_slot_match u_outer (
        .et      (hdr_et0),
        .slot_et (slot_et),
        .slot_en (outer_en),
        .hit     (outer_hit)
    );

    vtag_slot_match u_inner (
        .et      (hdr_et1),
        .slot_et (slot_et),
        .slot_en (inner_en),
        .hit     (inner_hit)
    );

    typedef struct packed {
        logic       valid;
        vtag_kind_e kind;
    } res_t;

    res_t res_d, res_q;

    // classification uses the configuration registered before this edge
    always_comb begin
        res_d.valid = hdr_valid;
        res_d.kind  = VT_UNTAGGED;
        if (hdr_valid && port_ok && outer_hit) begin
            res_d.kind = inner_hit ? VT_DOUBLE : VT_SINGLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '{valid: 1'b0, kind: VT_UNTAGGED};
        end else begin
            res_q <= res_d;
        end
    end

    assign cls_valid = res_q.valid;
    assign cls_kind  = res_q.kind;

endmodule

// File: rtl/vtag_classifier_chk.sv
module vtag_classifier_chk #(
    parameter int NUM_PORTS = 16,
    parameter int PORT_W    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hdr_valid,
    input logic [PORT_W-1:0] hdr_port,
    input logic              cls_valid,
    input logic [1:0]        cls_kind
);

    // R8
    result_follows_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> cls_valid);

    // R8
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cls_valid |-> $past(hdr_valid));

    // R1
    idle_kind_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cls_valid |-> (cls_kind == 2'b00));

    // R3
    kind_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cls_valid |-> (cls_kind != 2'b11));

    // R10
    oob_port_untagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && (int'(hdr_port) >= NUM_PORTS)) |=> (cls_kind == 2'b00));

endmodule

bind vtag_classifier vtag_classifier_chk #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hdr_valid (hdr_valid),
    .hdr_port  (hdr_port),
    .cls_valid (cls_valid),
    .cls_kind  (cls_kind)
);

// File: tb/tb_vtag_classifier.sv
`timescale 1ns/1ps
module tb_vtag_classifier;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_wr_sel = 1'b0;
    logic [7:0]  cfg_wr_idx = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        hdr_valid = 1'b0;
    logic [7:0]  hdr_port = '0;
    logic [15:0] hdr_et0 = '0;
    logic [15:0] hdr_et1 = '0;
    logic        cls_valid;
    logic [1:0]  cls_kind;

    always #2 clk = ~clk;

    vtag_classifier dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_sel  (cfg_wr_sel),
        .cfg_wr_idx  (cfg_wr_idx),
        .cfg_wr_data (cfg_wr_data),
        .hdr_valid   (hdr_valid),
        .hdr_port    (hdr_port),
        .hdr_et0     (hdr_et0),
        .hdr_et1     (hdr_et1),
        .cls_valid   (cls_valid),
        .cls_kind    (cls_kind)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // reference configuration kept by the bench
    bit [15:0] m_et [3];
    bit [31:0] m_en [16];

    function automatic void model_reset();
        m_et[0] = 16'h8100;
        m_et[1] = 16'h88A8;
        m_et[2] = 16'h9100;
        for (int p = 0; p < 16; p++) m_en[p] = 32'h0000_0303;
    endfunction

    function automatic void model_write(bit sel, bit [7:0] idx, bit [31:0] d);
        if (!sel) begin
            if (idx < 3) m_et[idx] = d[15:0];
        end else begin
            if (idx < 16) m_en[idx] = d;
        end
    endfunction

    function automatic bit [1:0] model_cls(bit [7:0] p, bit [15:0] e0, bit [15:0] e1);
        bit h0 = 0;
        bit h1 = 0;
        if (p >= 16) return 2'b00;
        for (int s = 0; s < 3; s++) begin
            if (m_en[p][8*s]   && e0 == m_et[s]) h0 = 1;
            if (m_en[p][8*s+1] && e1 == m_et[s]) h1 = 1;
        end
        if (!h0) return 2'b00;
        return h1 ? 2'b10 : 2'b01;
    endfunction

    task automatic check(bit ok, string req, bit av, bit [1:0] ak, bit ev, bit [1:0] ek);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual valid=%0b kind=%02b expected valid=%0b kind=%02b",
                     req, av, ak, ev, ek);
        end
    endtask

    // one cycle: drive at negedge, model at posedge, check at following negedge
    task automatic step(bit v, bit [7:0] p, bit [15:0] e0, bit [15:0] e1,
                        bit w, bit sel, bit [7:0] idx, bit [31:0] d, string req);
        bit       ev;
        bit [1:0] ek;
        hdr_valid   = v;
        hdr_port    = p;
        hdr_et0     = e0;
        hdr_et1     = e1;
        cfg_wr_en   = w;
        cfg_wr_sel  = sel;
        cfg_wr_idx  = idx;
        cfg_wr_data = d;
        @(posedge clk);
        ev = v;
        ek = v ? model_cls(p, e0, e1) : 2'b00;
        if (w) model_write(sel, idx, d);
        @(negedge clk);
        check(cls_valid == ev && cls_kind == ek, req, cls_valid, cls_kind, ev, ek);
    endtask

    task automatic frame(bit [7:0] p, bit [15:0] e0, bit [15:0] e1, string req);
        step(1, p, e0, e1, 0, 0, 0, 0, req);
    endtask

    task automatic wr(bit sel, bit [7:0] idx, bit [31:0] d, string req);
        step(0, 0, 0, 0, 1, sel, idx, d, req);
    endtask

    function automatic bit [15:0] pick_et();
        int r = $urandom % 6;
        if (r < 3) return m_et[r];
        if (r == 3) return 16'h0800;
        if (r == 4) return 16'($urandom);
        return m_et[0];
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        // R1: outputs idle during reset
        check(cls_valid == 0 && cls_kind == 0, "R1", cls_valid, cls_kind, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cls_valid == 0 && cls_kind == 0, "R1", cls_valid, cls_kind, 0, 0);

        // R5 defaults, R2/R3/R4 basic encodings
        frame(3, 16'h8100, 16'h8100, "R5 R3");
        frame(3, 16'h8100, 16'h0800, "R5 R2");
        frame(3, 16'h88A8, 16'h8100, "R5 R3");
        frame(3, 16'h9100, 16'h8100, "R5 slot2 outer clear");
        frame(3, 16'h8100, 16'h9100, "R5 slot2 inner clear");
        // R4: tag1 ignored when tag0 misses
        frame(3, 16'h0800, 16'h8100, "R4");
        // R8: idle cycle gives no valid
        step(0, 3, 16'h8100, 16'h8100, 0, 0, 0, 0, "R8");

        // R6: provider-style port 3, slot1 outer+inner only, reserved bits set
        wr(1, 3, 32'hFCFC_FF00 | 32'h0000_0300, "R6 write");
        frame(3, 16'h8100, 16'h0800, "R6 0x8100 untagged");
        frame(3, 16'h88A8, 16'h8100, "R6 inner 0x8100 off");
        frame(3, 16'h88A8, 16'h88A8, "R6 R3");
        // R11: other port unaffected
        frame(5, 16'h8100, 16'h8100, "R11");

        // R7: slot 2 write and enable, bad slot index ignored
        wr(0, 2, 32'hABCD_1234, "R7 write");
        wr(0, 5, 32'h0000_8100, "R7 bad idx");
        wr(1, 6, 32'h0003_0000, "R6 slot2 enables");
        frame(6, 16'h1234, 16'h1234, "R7 R3");
        frame(6, 16'h8100, 16'h0800, "R6 slot0 off");
        frame(6, 16'h9100, 16'h0800, "R7 old value gone");

        // R10: out-of-range port and aliasing write
        frame(20, 16'h8100, 16'h8100, "R10");
        frame(255, 16'h88A8, 16'h88A8, "R10");
        wr(1, 20, 32'h0, "R10 write");
        frame(4, 16'h8100, 16'h8100, "R10 alias port4");

        // R9: same-cycle write uses old config, next frame new
        step(1, 4, 16'h8100, 16'h8100, 1, 1, 4, 32'h0, "R9 old cfg");
        frame(4, 16'h8100, 16'h8100, "R9 new cfg");
        step(1, 7, 16'h8100, 16'h0800, 1, 0, 0, 32'h0000_0800, "R9 slot old");
        frame(7, 16'h8100, 16'h0800, "R9 slot new");
        frame(7, 16'h0800, 16'h0800, "R9 slot new R3");

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            bit       v   = ($urandom % 4) != 0;
            bit [7:0] p   = (($urandom % 10) == 0) ? 8'($urandom) : 8'($urandom % 16);
            bit       w   = ($urandom % 12) == 0;
            bit       sel = $urandom % 2;
            bit [7:0] idx = sel ? 8'($urandom % 20) : 8'($urandom % 4);
            bit [31:0] d  = sel ? $urandom : {16'($urandom), pick_et()};
            bit [15:0] e0 = pick_et();
            bit [15:0] e1 = pick_et();
            step(v, p, e0, e1, w, sel, idx, d, "R2,R3,R4,R8,R9,R11");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule